// File: doc/BRIEF.md
# Per-Channel Threshold Zero Suppressor

This block sits between a converter's sample stream and the writer of an event buffer. It holds one threshold per input channel in a small memory and compares each sample against the threshold of its channel. It then tells the buffer writer whether to store that sample. The sample value is passed on untouched: the threshold only decides whether the sample is kept, and is never subtracted from it. A channel can be switched off completely by a special threshold pattern. Its samples are then always dropped.

Software reads and writes the thresholds through a simple register port. There is one 32-bit register per channel, and the channel number is the register address. The threshold memory has no reset, so a power-up or a master reset leaves every entry at its last written value. For each event the block also keeps a flag that shows whether any sample has been kept so far. A scan responder on the system bus can use this flag to report "data present".

Top module: `thr_zero_suppress`

## Requirements
- R1: While reset is asserted and right after it is released, `out_valid`, `out_keep`, `reg_rvalid` and `evt_any_kept` are 0.
- R2: A register write (`reg_req`=1, `reg_we`=1) stores `reg_wdata[12:0]` as the threshold of channel `reg_addr`. A register read (`reg_req`=1, `reg_we`=0) returns that threshold one cycle later on `reg_rdata` with `reg_rvalid`=1.
- R3: Write data bits 31..13 are discarded, and `reg_rdata` bits 31..13 always read as 0.
- R4: A sample whose value is below its channel threshold gives `out_keep`=0. A value equal to or above the threshold gives `out_keep`=1.
- R5: Each sample accepted with `smp_valid`=1 appears exactly one cycle later with `out_valid`=1, the same `out_chan` and the same `out_data`. The data is never reduced by the threshold.
- R6: A threshold with bits 12 and 11 both set disables its channel, and every sample of that channel gives `out_keep`=0. Either bit set on its own is an ordinary threshold.
- R7: Reset does not change the threshold memory. Entries read back, and filter samples, with the values written before the reset.
- R8: A threshold write in the same cycle as a sample from the same channel affects only the later samples. The current sample is judged against the old threshold.
- R9: `evt_any_kept` goes to 1 in the same cycle that a sample appears with `out_keep`=1, and stays at 1 until `evt_clear` is applied. `evt_clear` sets it to 0 on the next cycle, unless the sample judged in that same cycle is kept, in which case it reads 1.
- R10: A write to one channel leaves every other channel's threshold unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| reg_req | input | 1 | Register access request, accepted in every cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 6 | Register index, equal to the channel number |
| reg_wdata | input | 32 | Write data; only bits 12..0 are used |
| reg_rvalid | output | 1 | Read data valid, one cycle after a read request |
| reg_rdata | output | 32 | Read data, threshold zero-extended |
| smp_valid | input | 1 | Sample present |
| smp_chan | input | 6 | Sample channel number |
| smp_data | input | 13 | Sample value |
| evt_clear | input | 1 | Start of a new event; clears the kept flag |
| out_valid | output | 1 | Judged sample present |
| out_keep | output | 1 | 1 = buffer writer stores this sample |
| out_chan | output | 6 | Channel of the judged sample |
| out_data | output | 13 | Unmodified sample value |
| evt_any_kept | output | 1 | At least one sample of this event was kept |

## Verification
The bench tests the compare boundary on both sides, with the value one below the threshold, the threshold itself, one above it and full scale. A design that used a strict greater-than would drop samples equal to the threshold. It checks that the disable pattern needs both high bits: a design that tested only one bit would drop too much, and one that ignored the pattern would keep full-scale samples. It writes a threshold in the same cycle as a sample from that channel, which catches a memory that forwards the new value. It also resets the block midway, which catches threshold storage that was given a reset. Finally, it clears the event flag while a kept sample is judged, to pin down the priority between clear and set.

// File: rtl/thr_pkg.sv
package thr_pkg;
  localparam int unsigned THR_CH_N_DEF   = 64;
  localparam int unsigned THR_DATA_W_DEF = 13;
  localparam int unsigned THR_BUS_W_DEF  = 32;
  // number of top threshold bits that, all set, switch a channel off
  localparam int unsigned THR_KILL_W     = 2;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } reg_op_e;
endpackage

// File: rtl/thr_rst_sync.sv
module thr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/thr_mem.sv
module thr_mem #(
  parameter int unsigned CH_N   = 64,
  parameter int unsigned DATA_W = 13,
  localparam int unsigned AW    = $clog2(CH_N)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     smp_addr,
  output logic [DATA_W-1:0] smp_thr,
  input  logic [AW-1:0]     reg_addr,
  output logic [DATA_W-1:0] reg_thr
);
  // Threshold storage: deliberately without reset so entries survive it.
  logic [DATA_W-1:0] mem_q [CH_N];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  // Reads are combinational and see the contents before this cycle's write.
  assign smp_thr = mem_q[smp_addr];
  assign reg_thr = mem_q[reg_addr];
endmodule

// File: rtl/thr_cmp.sv
module thr_cmp #(
  parameter int unsigned DATA_W = 13,
  parameter int unsigned KILL_W = 2
) (
  input  logic [DATA_W-1:0] thr,
  input  logic [DATA_W-1:0] data,
  output logic              keep
);
  logic kill;

  always_comb begin
    kill = &thr[DATA_W-1 -: KILL_W];
    keep = !kill && (data >= thr);
  end
endmodule

// File: rtl/thr_zero_suppress.sv
module thr_zero_suppress
  import thr_pkg::*;
#(
  parameter int unsigned CH_N   = THR_CH_N_DEF,
  parameter int unsigned DATA_W = THR_DATA_W_DEF,
  parameter int unsigned BUS_W  = THR_BUS_W_DEF,
  localparam int unsigned AW    = $clog2(CH_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_req,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic              reg_rvalid,
  output logic [BUS_W-1:0]  reg_rdata,
  input  logic              smp_valid,
  input  logic [AW-1:0]     smp_chan,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              evt_clear,
  output logic              out_valid,
  output logic              out_keep,
  output logic [AW-1:0]     out_chan,
  output logic [DATA_W-1:0] out_data,
  output logic              evt_any_kept
);
  logic              rst_sn;
  reg_op_e           op;
  logic [DATA_W-1:0] smp_thr, reg_thr;
  logic              keep_c;

  logic              valid_d, keep_d, flag_d, rvalid_d;
  logic [BUS_W-1:0]  rdata_d;
  logic              valid_q, keep_q, flag_q, rvalid_q;
  logic [BUS_W-1:0]  rdata_q;
  logic [AW-1:0]     chan_q;
  logic [DATA_W-1:0] data_q;

  thr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  always_comb begin
    if (!reg_req)    op = OP_IDLE;
    else if (reg_we) op = OP_WRITE;
    else             op = OP_READ;
  end

  thr_mem #(.CH_N(CH_N), .DATA_W(DATA_W)) u_mem (
    .clk      (clk),
    .wr_en    (op == OP_WRITE),
    .wr_addr  (reg_addr),
    .wr_data  (reg_wdata[DATA_W-1:0]),
    .smp_addr (smp_chan),
    .smp_thr  (smp_thr),
    .reg_addr (reg_addr),
    .reg_thr  (reg_thr)
  );

  thr_cmp #(.DATA_W(DATA_W), .KILL_W(THR_KILL_W)) u_cmp (
    .thr(smp_thr), .data(smp_data), .keep(keep_c)
  );

  // next state
  always_comb begin
    valid_d  = smp_valid;
    keep_d   = smp_valid && keep_c;
    flag_d   = keep_d || (flag_q && !evt_clear);
    rvalid_d = (op == OP_READ);
    rdata_d  = (op == OP_READ) ? BUS_W'(reg_thr) : '0;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      valid_q  <= 1'b0;
      keep_q   <= 1'b0;
      flag_q   <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      valid_q  <= valid_d;
      keep_q   <= keep_d;
      flag_q   <= flag_d;
      rvalid_q <= rvalid_d;
      rdata_q  <= rdata_d;
    end
  end

  // datapath registers, loaded only when a sample is present
  always_ff @(posedge clk) begin
    if (smp_valid) begin
      chan_q <= smp_chan;
      data_q <= smp_data;
    end
  end

  assign out_valid    = valid_q;
  assign out_keep     = keep_q;
  assign out_chan     = chan_q;
  assign out_data     = data_q;
  assign evt_any_kept = flag_q;
  assign reg_rvalid   = rvalid_q;
  assign reg_rdata    = rdata_q;

  AST_DATA_PASSED: assert property (@(posedge clk) disable iff (!rst_sn)
    out_valid |-> (out_data == $past(smp_data) && out_chan == $past(smp_chan))); // R5
  AST_KEEP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_sn)
    out_keep |-> out_valid); // R4
  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_sn)
    (reg_req && !reg_we) |=> reg_rvalid); // R2
  AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_sn)
    reg_rvalid |-> (reg_rdata[BUS_W-1:DATA_W] == '0)); // R3
  AST_FLAG_ON_KEEP: assert property (@(posedge clk) disable iff (!rst_sn)
    (out_valid && out_keep) |-> evt_any_kept); // R9
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_sn)
    (evt_any_kept && !evt_clear) |=> evt_any_kept); // R9
endmodule

// File: tb/thr_zero_suppress_bench.sv
module thr_zero_suppress_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_req, reg_we;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic        reg_rvalid;
  logic [31:0] reg_rdata;
  logic        smp_valid;
  logic [5:0]  smp_chan;
  logic [12:0] smp_data;
  logic        evt_clear;
  logic        out_valid, out_keep;
  logic [5:0]  out_chan;
  logic [12:0] out_data;
  logic        evt_any_kept;

  int errors = 0;
  int checks = 0;
  logic [12:0] shadow [64];
  logic [19:0] expq [$];   // {keep, chan, data}

  always #2 clk = ~clk;   // 250 MHz

  thr_zero_suppress u_thr_zero_suppress (
    .clk(clk), .rst_n(rst_n),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
    .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_data(smp_data),
    .evt_clear(evt_clear),
    .out_valid(out_valid), .out_keep(out_keep), .out_chan(out_chan), .out_data(out_data),
    .evt_any_kept(evt_any_kept)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit model_keep(input logic [12:0] thr, input logic [12:0] d);
    return !(thr[12] && thr[11]) && (d >= thr);
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (out_valid) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R5", "unexpected output sample", 1, 0);
      end else begin
        logic [19:0] e;
        e = expq.pop_front();
        chk(out_keep == e[19], "R4/R6/R8", "keep decision", out_keep, e[19]);
        chk(out_chan == e[18:13], "R5", "channel passthrough", out_chan, e[18:13]);
        chk(out_data == e[12:0], "R5", "data passthrough unmodified", out_data, e[12:0]);
      end
    end
  end

  task automatic reg_write(input int ch, input logic [31:0] v);
    @(negedge clk);
    reg_req = 1; reg_we = 1; reg_addr = 6'(ch); reg_wdata = v;
    @(negedge clk);
    reg_req = 0; reg_we = 0;
    shadow[ch] = v[12:0];
  endtask

  task automatic reg_read(input int ch, input string tag);
    @(negedge clk);
    reg_req = 1; reg_we = 0; reg_addr = 6'(ch);
    @(negedge clk);
    reg_req = 0;
    chk(reg_rvalid == 1'b1, tag, "read valid", reg_rvalid, 1);
    chk(reg_rdata == {19'd0, shadow[ch]}, tag, "read data", reg_rdata, {19'd0, shadow[ch]});
  endtask

  // sample, optionally with a same-cycle write to a channel and/or event clear
  task automatic send(input int ch, input int d, input bit clr,
                      input bit wr, input logic [31:0] wv);
    @(negedge clk);
    smp_valid = 1; smp_chan = 6'(ch); smp_data = 13'(d); evt_clear = clr;
    expq.push_back({model_keep(shadow[ch], 13'(d)), 6'(ch), 13'(d)});
    if (wr) begin
      reg_req = 1; reg_we = 1; reg_addr = 6'(ch); reg_wdata = wv;
    end
    @(negedge clk);
    smp_valid = 0; evt_clear = 0; reg_req = 0; reg_we = 0;
    if (wr) shadow[ch] = wv[12:0];
  endtask

  task automatic clear_evt;
    @(negedge clk);
    evt_clear = 1;
    @(negedge clk);
    evt_clear = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; reg_req = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    smp_valid = 0; smp_chan = 0; smp_data = 0; evt_clear = 0;
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && out_keep == 0, "R1", "outputs in reset", out_valid, 0);
    chk(reg_rvalid == 0 && evt_any_kept == 0, "R1", "rvalid/flag in reset", evt_any_kept, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && evt_any_kept == 0, "R1", "after reset release", out_valid, 0);

    for (int c = 0; c < 64; c++) reg_write(c, 32'(c * 50));
    reg_read(0, "R2"); reg_read(37, "R2"); reg_read(63, "R2");
    reg_write(9, 32'hABCD_E000 | 32'd123);
    reg_read(9, "R3");

    // R4 boundary, R5 passthrough (ch10 threshold 500)
    clear_evt();
    send(10, 499, 0, 0, 0);
    chk(evt_any_kept == 0, "R9", "flag after dropped sample", evt_any_kept, 0);
    send(10, 500, 0, 0, 0);
    chk(evt_any_kept == 1, "R9", "flag after kept sample", evt_any_kept, 1);
    send(10, 501, 0, 0, 0);
    send(10, 8191, 0, 0, 0);
    send(0, 0, 0, 0, 0);

    // R6 disable pattern and single-bit thresholds
    reg_write(20, 32'h1800);
    send(20, 8191, 0, 0, 0);
    send(20, 0, 0, 0, 0);
    reg_write(21, 32'h1000);
    send(21, 4096, 0, 0, 0);
    send(21, 4095, 0, 0, 0);
    reg_write(22, 32'h0800);
    send(22, 2048, 0, 0, 0);
    send(22, 2047, 0, 0, 0);

    // R8 same-cycle write (ch30 threshold 1500 -> 2000)
    send(30, 1800, 0, 1, 32'd2000);
    send(30, 1800, 0, 0, 0);
    reg_read(30, "R8");

    // R9 flag hold and clear priority
    send(1, 10, 0, 0, 0);
    send(1, 0, 0, 0, 0);
    chk(evt_any_kept == 1, "R9", "flag holds until clear", evt_any_kept, 1);
    clear_evt();
    chk(evt_any_kept == 0, "R9", "flag cleared", evt_any_kept, 0);
    send(2, 200, 1, 0, 0);
    chk(evt_any_kept == 1, "R9", "keep wins over same-cycle clear", evt_any_kept, 1);
    send(2, 50, 1, 0, 0);
    chk(evt_any_kept == 0, "R9", "clear with dropped sample", evt_any_kept, 0);

    // R10 neighbour isolation
    reg_write(5, 32'd7);
    reg_read(6, "R10"); reg_read(4, "R10"); reg_read(5, "R10");

    // R7 thresholds survive reset
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk(evt_any_kept == 0 && out_valid == 0, "R1", "second reset clears flag", evt_any_kept, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    reg_read(10, "R7"); reg_read(20, "R7"); reg_read(30, "R7");
    send(10, 499, 0, 0, 0);
    send(20, 8000, 0, 0, 0);
    send(30, 2000, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R5", "all samples emerged", expq.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule